// File: doc/BRIEF.md
# UART Register and Interrupt Front End

This block is the bus-facing register file of a UART. A processor reaches it through a simple 32-bit read/write port. The port decodes a 64-byte window as sixteen word slots. Behind the data slot sit a 16-entry transmit queue and a 16-entry receive queue. The block gathers line errors into a sticky status word and reports queue and modem-line state in a flag word. It merges four interrupt sources into one request line.

The serial engine itself lies outside this block. The front end hands the engine its line configuration, baud divisor, enable and loopback settings. It offers transmit bytes on a valid/ready handshake and accepts received bytes as single-cycle strobes, each with frame, parity and break qualifiers. The engine also reports two more signals here: whether it is still shifting a frame, and a receive-idle timeout pulse.

Top module: `uart_regfile`

## Requirements
- R1: After reset, the flag word (offset 0x18) reads 0x90 when CTS, DSR and DCD are low. The control word, status word and interrupt ID read 0, `irq` is low, the receive threshold reads 1 and the transmit threshold reads 0.
- R2: The line word (0x08) holds 8 bits and drives `line_cfg`. The divisor slots 0x0C (high byte) and 0x10 (low byte) drive `baud_div`. The control word (0x14) keeps bits 0 and 3 to 7, reads bits 1 and 2 as 0, and drives `uart_en` from bit 0 and `loop_en` from bit 7. The receive threshold (0x38) and transmit threshold (0x3C) hold 5 bits each. Offsets with no register read 0 and ignore writes.
- R3: A write to 0x00 queues bits 7:0 for transmission. While control bit 0 is set, queued bytes are offered on `tx_data`/`tx_valid` in write order, and each is removed when `tx_ready` is high. A write that finds 16 bytes queued is dropped.
- R4: A read of 0x00 returns the oldest received byte in bits 7:0 and removes it. A read of an empty receive queue returns 0 and changes nothing.
- R5: A received byte that arrives while 16 bytes are held is discarded and sets status bit 3 (overrun). The held bytes are kept.
- R6: A byte strobe with frame, parity or break qualifiers sets status bits 0, 1 or 2. The bits stay set until any write to 0x04 clears all four. An error arriving in the same cycle as that write stays set.
- R7: The flag word holds CTS in bit 0, DSR in bit 1 and DCD in bit 2. Bit 4 is receive empty, bit 5 is transmit full, bit 6 is receive full and bit 7 is transmit empty.
- R8: Flag bit 3 (busy) is 1 while the transmit queue holds a byte or `tx_active` is high.
- R9: Interrupt ID bit 1 is set while the receive fill count is at or above the receive threshold and control bit 4 is set.
- R10: Interrupt ID bit 2 is set while the transmit fill count is at or below the transmit threshold and control bit 5 is set.
- R11: A change of `cts_in` while control bit 3 is set latches interrupt ID bit 0. Any write to 0x1C clears it.
- R12: A `rx_tmo` pulse while control bit 6 is set latches interrupt ID bit 3. Any write to 0x1C clears it.
- R13: `irq` is high exactly when any of the four interrupt ID bits is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Byte address in the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_sel is high |
| tx_data | output | 8 | Oldest queued transmit byte |
| tx_valid | output | 1 | Transmit byte offered to the engine |
| tx_ready | input | 1 | Engine accepts the offered byte |
| tx_active | input | 1 | Engine is shifting a frame |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_ferr | input | 1 | Frame error on this byte |
| rx_perr | input | 1 | Parity error on this byte |
| rx_brk | input | 1 | Break seen on this byte |
| rx_tmo | input | 1 | Receive idle timeout pulse |
| cts_in | input | 1 | Clear-to-send line |
| dsr_in | input | 1 | Data-set-ready line |
| dcd_in | input | 1 | Carrier-detect line |
| line_cfg | output | 8 | Line configuration to the engine |
| baud_div | output | 16 | Baud divisor to the engine |
| uart_en | output | 1 | Engine enable |
| loop_en | output | 1 | Loopback select |
| irq | output | 1 | Interrupt request |

## Verification
Some behaviours are checked by the embedded assertions on every cycle. These are overrun marking and retention of a full receive queue, dropping of a transmit write into a full queue, the one-byte decrement on a receive pop, the status clear, the latch of a CTS change into a request, and the transmit-level request. Other behaviours need the bench's sweeps, which walk fill counts against several thresholds. These are byte ordering through both queues, the exact flag and ID encodings at every fill level, the mask of the control word, the same-cycle rule for error versus clear, and the ignoring of unmapped offsets.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [5:0]    bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready,
  input  logic          tx_active,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_valid,
  input  logic          rx_ferr,
  input  logic          rx_perr,
  input  logic          rx_brk,
  input  logic          rx_tmo,
  input  logic          cts_in,
  input  logic          dsr_in,
  input  logic          dcd_in,
  output logic [7:0]    line_cfg,
  output logic [15:0]   baud_div,
  output logic          uart_en,
  output logic          loop_en,
  output logic          irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt, rx_thr, tx_thr;
  logic [3:0]    sts;
  logic [7:0]    ctrl, div_hi, div_lo, line_r;
  logic          mis, rtis, cts_q;

  wire [3:0] widx   = bus_addr[5:2];
  wire wr_en        = bus_sel & bus_wr;
  wire rd_en        = bus_sel & ~bus_wr;
  wire tx_full      = (tx_cnt == FULL);
  wire tx_empty     = (tx_cnt == '0);
  wire rx_full      = (rx_cnt == FULL);
  wire rx_empty     = (rx_cnt == '0);
  wire tx_push      = wr_en && widx == 4'd0 && !tx_full;
  wire tx_pop       = tx_valid && tx_ready;
  wire rx_push      = rx_valid && !rx_full;
  wire rx_pop       = rd_en && widx == 4'd0 && !rx_empty;
  wire ris          = ctrl[4] && (rx_cnt >= rx_thr);
  wire tis          = ctrl[5] && (tx_cnt <= tx_thr);
  wire [3:0] iir    = {rtis, tis, ris, mis};
  wire busy         = !tx_empty || tx_active;
  wire [7:0] flags  = {tx_empty, rx_full, tx_full, rx_empty, busy, dcd_in, dsr_in, cts_in};

  assign tx_valid = ctrl[0] && !tx_empty;
  assign tx_data  = tx_mem[tx_rp];
  assign line_cfg = line_r;
  assign baud_div = {div_hi, div_lo};
  assign uart_en  = ctrl[0];
  assign loop_en  = ctrl[7];
  assign irq      = |iir;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[DW-1:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
      rx_thr <= CW'(1); tx_thr <= '0;
      sts <= '0; ctrl <= '0; div_hi <= '0; div_lo <= '0; line_r <= '0;
      mis <= 1'b0; rtis <= 1'b0; cts_q <= 1'b0;
    end else begin
      cts_q <= cts_in;
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
      sts <= ((wr_en && widx == 4'd1) ? 4'd0 : sts)
           | {rx_valid & rx_full, rx_valid & rx_brk, rx_valid & rx_perr, rx_valid & rx_ferr};
      mis  <= ((wr_en && widx == 4'd7) ? 1'b0 : mis)  | (ctrl[3] && cts_in != cts_q);
      rtis <= ((wr_en && widx == 4'd7) ? 1'b0 : rtis) | (ctrl[6] && rx_tmo);
      if (wr_en) begin
        case (widx)
          4'd2:  line_r <= bus_wdata[7:0];
          4'd3:  div_hi <= bus_wdata[7:0];
          4'd4:  div_lo <= bus_wdata[7:0];
          4'd5:  ctrl   <= bus_wdata[7:0] & 8'hF9;
          4'd14: rx_thr <= bus_wdata[CW-1:0];
          4'd15: tx_thr <= bus_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (widx)
      4'd0:    bus_rdata = rx_empty ? 32'd0 : 32'(rx_mem[rx_rp]);
      4'd1:    bus_rdata = 32'(sts);
      4'd2:    bus_rdata = 32'(line_r);
      4'd3:    bus_rdata = 32'(div_hi);
      4'd4:    bus_rdata = 32'(div_lo);
      4'd5:    bus_rdata = 32'(ctrl);
      4'd6:    bus_rdata = 32'(flags);
      4'd7:    bus_rdata = 32'(iir);
      4'd14:   bus_rdata = 32'(rx_thr);
      4'd15:   bus_rdata = 32'(tx_thr);
      default: bus_rdata = 32'd0;
    endcase
  end

  AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full |=> sts[3]); // R5
  AST_RX_KEEP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_full && !rx_pop |=> rx_full); // R5
  AST_TX_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && widx == 4'd0 && tx_full && !tx_pop |=> tx_full && $stable(tx_wp)); // R3
  AST_RX_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop && !rx_valid |=> rx_cnt == $past(rx_cnt) - CW'(1)); // R4
  AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && widx == 4'd1 && !rx_valid |=> sts == 4'd0); // R6
  AST_CTS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[3] && cts_in != cts_q |=> irq); // R11
  AST_TX_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[5] && tx_cnt <= tx_thr |-> irq); // R10
endmodule

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_wr = 0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [7:0] tx_data, rx_data = '0, line_cfg;
  logic tx_valid, tx_ready = 0, tx_active = 0;
  logic rx_valid = 0, rx_ferr = 0, rx_perr = 0, rx_brk = 0, rx_tmo = 0;
  logic cts_in = 0, dsr_in = 0, dcd_in = 0;
  logic [15:0] baud_div;
  logic uart_en, loop_en, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_regfile dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] v);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rx_put(logic [7:0] d, logic fe, logic pe, logic bk);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_ferr = fe; rx_perr = pe; rx_brk = bk;
    @(negedge clk); rx_valid = 0; rx_ferr = 0; rx_perr = 0; rx_brk = 0;
  endtask

  task automatic tx_take(output logic [7:0] v);
    @(negedge clk);
    while (!tx_valid) @(negedge clk);
    v = tx_data; tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: got 0x0 expected 0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [7:0] b;
    int cnt;
    int thr_tx[3] = '{0, 5, 15};
    int thr_rx[3] = '{1, 4, 16};
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(6'h18, v); chk("R1 flags", v, 32'h90);
    rd(6'h14, v); chk("R1 ctrl", v, 0);
    rd(6'h04, v); chk("R1 status", v, 0);
    rd(6'h1C, v); chk("R1 iid", v, 0);
    chk("R1 irq", irq, 0);
    rd(6'h38, v); chk("R1 rx thr", v, 1);
    rd(6'h3C, v); chk("R1 tx thr", v, 0);
    // R2 configuration registers
    wr(6'h08, 32'hFFFF_FFA5); rd(6'h08, v); chk("R2 line", v, 32'hA5);
    chk("R2 line_cfg", line_cfg, 8'hA5);
    wr(6'h0C, 32'h12); wr(6'h10, 32'h34);
    chk("R2 baud_div", baud_div, 16'h1234);
    wr(6'h14, 32'hFF); rd(6'h14, v); chk("R2 ctrl mask", v, 32'hF9);
    chk("R2 uart_en", uart_en, 1); chk("R2 loop_en", loop_en, 1);
    wr(6'h14, 0);
    wr(6'h20, 32'h5A); rd(6'h20, v); chk("R2 unmapped", v, 0);
    wr(6'h34, 32'h5A); rd(6'h34, v); chk("R2 unmapped", v, 0);
    rd(6'h08, v); chk("R2 line kept", v, 32'hA5);
    // R3 R7 R8 R10 transmit sweep
    for (int t = 0; t < 3; t++) begin
      wr(6'h3C, thr_tx[t]); wr(6'h14, 32'h20);
      for (int k = 0; k <= 17; k++) begin
        if (k > 0) wr(6'h00, 32'hAB00 + t * 20 + k);
        cnt = (k > 16) ? 16 : k;
        rd(6'h18, v);
        chk("R7 tx full", v[5], cnt == 16);
        chk("R7 tx empty", v[7], cnt == 0);
        chk("R8 busy", v[3], cnt != 0);
        rd(6'h1C, v);
        chk("R10 tx level", v[2], cnt <= thr_tx[t]);
        chk("R13 irq", irq, cnt <= thr_tx[t]);
      end
      wr(6'h14, 32'h21);
      for (int j = 1; j <= 16; j++) begin
        tx_take(b); chk("R3 order", b, 8'(t * 20 + j));
      end
      wr(6'h14, 32'h20);
      rd(6'h18, v); chk("R3 drained", v[7], 1);
    end
    wr(6'h14, 0);
    tx_active = 1; rd(6'h18, v); chk("R8 busy engine", v[3], 1);
    tx_active = 0; rd(6'h18, v); chk("R8 idle", v[3], 0);
    // R4 R5 R7 R9 receive sweep
    for (int t = 0; t < 3; t++) begin
      wr(6'h38, thr_rx[t]); wr(6'h14, 32'h10);
      rd(6'h1C, v); chk("R9 empty", v[1], 0);
      for (int k = 1; k <= 16; k++) begin
        rx_put(8'(k * 7 + t), 0, 0, 0);
        rd(6'h1C, v); chk("R9 rx level", v[1], k >= thr_rx[t]);
        rd(6'h18, v);
        chk("R7 rx full", v[6], k == 16); chk("R7 rx empty", v[4], 0);
      end
      rx_put(8'hEE, 0, 0, 0);
      rd(6'h04, v); chk("R5 overrun", v, 8);
      for (int k = 1; k <= 16; k++) begin
        rd(6'h00, v); chk("R4 rx order", v, 32'(8'(k * 7 + t)));
      end
      rd(6'h00, v); chk("R4 empty read", v, 0);
      rd(6'h18, v); chk("R4 stays empty", v[4], 1);
      wr(6'h04, 0); rd(6'h04, v); chk("R6 clear", v, 0);
    end
    wr(6'h14, 0);
    // R6 error bits
    rx_put(8'h01, 1, 0, 0); rd(6'h04, v); chk("R6 frame", v, 1);
    rx_put(8'h02, 0, 1, 0); rd(6'h04, v); chk("R6 parity", v, 3);
    rx_put(8'h03, 0, 0, 1); rd(6'h04, v); chk("R6 break", v, 7);
    wr(6'h04, 32'h1234); rd(6'h04, v); chk("R6 any write clears", v, 0);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 6'h04; rx_valid = 1; rx_perr = 1; rx_data = 8'h04;
    @(negedge clk); bus_sel = 0; bus_wr = 0; rx_valid = 0; rx_perr = 0;
    rd(6'h04, v); chk("R6 set wins", v, 2);
    for (int k = 0; k < 4; k++) rd(6'h00, v);
    wr(6'h04, 0);
    // R7 R11 modem lines
    dsr_in = 1; dcd_in = 1; rd(6'h18, v); chk("R7 modem lines", v[2:0], 3'b110);
    dsr_in = 0; dcd_in = 0;
    cts_in = 1; repeat (2) @(negedge clk);
    rd(6'h1C, v); chk("R11 masked", v, 0);
    rd(6'h18, v); chk("R7 cts", v[0], 1);
    wr(6'h14, 32'h08);
    cts_in = 0; repeat (2) @(negedge clk);
    rd(6'h1C, v); chk("R11 latched", v, 1); chk("R13 irq modem", irq, 1);
    wr(6'h1C, 0); rd(6'h1C, v); chk("R11 ack", v, 0); chk("R13 irq low", irq, 0);
    // R12 timeout
    wr(6'h14, 0);
    @(negedge clk); rx_tmo = 1; @(negedge clk); rx_tmo = 0;
    rd(6'h1C, v); chk("R12 masked", v, 0);
    wr(6'h14, 32'h40);
    @(negedge clk); rx_tmo = 1; @(negedge clk); rx_tmo = 0;
    rd(6'h1C, v); chk("R12 latched", v, 8); chk("R13 irq tmo", irq, 1);
    wr(6'h1C, 0); rd(6'h1C, v); chk("R12 ack", v, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule